// File: doc/BRIEF.md
# RF Front-End Transmit Lead-Time Sequencer

This block drives two complementary switch lines for an external RF front-end and staggers the turn-on of an internal power-amplifier buffer and the power amplifier ahead of each transmitted frame. The switch lines follow the transceiver's transmit-busy indication, but only while front-end control is enabled. When control is disabled, both lines stay low.

A start request turns on the buffer enable at once. After a programmable buffer lead time it turns on the PA enable. After a second programmable PA lead time it emits a one-cycle strobe that marks the start of the frame header. Both lead times are counted in ticks of a one-cycle microsecond pulse.

The block holds a small configuration register with three fields: the control enable, the buffer lead-time code and the PA lead-time code. The lead-time codes are captured when a frame starts, so a register write made during a frame applies from the next frame. When the transmit-busy indication drops, both amplifier enables turn off in the same cycle.

Top module: `rf_fe_seq`

## Requirements
- R1: After reset the configuration holds front-end control off, buffer lead code 3 and PA lead code 0, and all outputs are low. The first frame after reset therefore shows a 6-tick buffer lead and a 2-tick PA lead.
- R2: While the registered control enable is 0, `fe_tx_pin` and `fe_rx_pin` are both low in the next cycle, whatever the value of `tx_busy`.
- R3: While the control enable is 1 and `tx_busy` is 1, the next cycle has `fe_tx_pin`=1 and `fe_rx_pin`=0.
- R4: While the control enable is 1 and `tx_busy` is 0, the next cycle has `fe_tx_pin`=0 and `fe_rx_pin`=1.
- R5: A `start_req` seen while idle raises `pa_buf_en` in the next cycle.
- R6: `pa_en` rises in the cycle after the 2×B-th `us_tick` counted while `pa_buf_en`=1 and `pa_en`=0, where B is the buffer lead code. When B=0, `pa_en` rises in the same cycle as `pa_buf_en`.
- R7: `shr_start` is high for exactly one cycle. That cycle follows the 2×(P+1)-th `us_tick` counted while `pa_en`=1, where P is the PA lead code, so codes 0..3 give 2, 4, 6 and 8 ticks.
- R8: While a frame is active (from `start_req` acceptance until the return to idle), a cycle with `tx_busy`=0 clears `pa_buf_en` and `pa_en` together in the next cycle, and the block returns to idle.
- R9: Both lead codes are sampled when a start is accepted. A configuration write made during a frame changes only later frames.
- R10: A `start_req` that arrives while a frame is active is ignored and does not change the frame's timing.
- R11: `pa_en` is never high while `pa_buf_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_fe_en | input | 1 | Write data: front-end control enable |
| cfg_buf_lt | input | 2 | Write data: buffer lead-time code |
| cfg_pa_lt | input | 2 | Write data: PA lead-time code |
| tx_busy | input | 1 | Transceiver is in its transmit-busy state |
| start_req | input | 1 | Request to start a frame |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| fe_tx_pin | output | 1 | Front-end line, high during transmit |
| fe_rx_pin | output | 1 | Front-end line, high outside transmit |
| pa_buf_en | output | 1 | PA buffer enable |
| pa_en | output | 1 | Power amplifier enable |
| shr_start | output | 1 | One-cycle header-start strobe |

## Verification
The assertions check the following on every cycle: the switch-line levels after each enable and busy combination, the ordering of `pa_en` under `pa_buf_en`, the single-cycle strobe, the joint shutdown when busy drops, and acceptance of an idle start. Only the bench's scenarios can show the tick counts of the two lead windows for each code, the reset defaults seen through the first frame, the capture of codes at acceptance across a mid-frame write, and the unchanged timing when a second start arrives. The bench compares every output against a behavioural model on each clock and also measures the lead windows directly from the ports.

// File: rtl/rf_fe_pkg.sv
package rf_fe_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_BUF,
    PH_PA,
    PH_AIR
  } phase_t;

  typedef struct packed {
    logic              fe_en;
    logic [CODE_W-1:0] buf_lt;
    logic [CODE_W-1:0] pa_lt;
  } fe_cfg_t;
endpackage

// File: rtl/rf_fe_cfg.sv
module rf_fe_cfg
  import rf_fe_pkg::*;
#(
  parameter logic [CODE_W-1:0] BUF_LT_RST = CODE_W'(3),
  parameter logic [CODE_W-1:0] PA_LT_RST  = CODE_W'(0)
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    we,
  input  fe_cfg_t wdata,
  output fe_cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.fe_en  <= 1'b0;
      cfg.buf_lt <= BUF_LT_RST;
      cfg.pa_lt  <= PA_LT_RST;
    end else if (we) begin
      cfg <= wdata;
    end
  end
endmodule

// File: rtl/rf_fe_pins.sv
module rf_fe_pins (
  input  logic clk,
  input  logic rst,
  input  logic fe_en,
  input  logic tx_busy,
  output logic tx_pin,
  output logic rx_pin
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pin <= 1'b0;
      rx_pin <= 1'b0;
    end else begin
      tx_pin <= fe_en & tx_busy;
      rx_pin <= fe_en & ~tx_busy;
    end
  end

  // R2
  pins_off_chk: assert property (@(posedge clk) disable iff (rst)
    !fe_en |=> (!tx_pin && !rx_pin));
  // R3
  pins_tx_chk: assert property (@(posedge clk) disable iff (rst)
    (fe_en && tx_busy) |=> (tx_pin && !rx_pin));
  // R4
  pins_rx_chk: assert property (@(posedge clk) disable iff (rst)
    (fe_en && !tx_busy) |=> (!tx_pin && rx_pin));
endmodule

// File: rtl/rf_fe_lead_seq.sv
module rf_fe_lead_seq
  import rf_fe_pkg::*;
#(
  parameter int LT_STEP = 2,
  localparam int MAX_TICKS = LT_STEP * (2 ** CODE_W),
  localparam int CNT_W = $clog2(MAX_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] buf_lt,
  input  logic [CODE_W-1:0] pa_lt,
  input  logic              tx_busy,
  input  logic              start_req,
  input  logic              us_tick,
  output logic              buf_en,
  output logic              pa_en,
  output logic              shr
);
  phase_t            phase;
  logic [CNT_W-1:0]  left;
  logic [CODE_W-1:0] pa_hold;

  function automatic logic [CNT_W-1:0] buf_ticks(input logic [CODE_W-1:0] c);
    return CNT_W'(LT_STEP * int'(c));
  endfunction

  function automatic logic [CNT_W-1:0] pa_ticks(input logic [CODE_W-1:0] c);
    return CNT_W'(LT_STEP * (int'(c) + 1));
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      buf_en  <= 1'b0;
      pa_en   <= 1'b0;
      shr     <= 1'b0;
      left    <= '0;
      pa_hold <= '0;
    end else begin
      shr <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start_req) begin
          buf_en  <= 1'b1;
          pa_hold <= pa_lt;
          if (buf_lt == '0) begin
            pa_en <= 1'b1;
            left  <= pa_ticks(pa_lt);
            phase <= PH_PA;
          end else begin
            left  <= buf_ticks(buf_lt);
            phase <= PH_BUF;
          end
        end
      end else if (!tx_busy) begin
        buf_en <= 1'b0;
        pa_en  <= 1'b0;
        phase  <= PH_IDLE;
      end else if (us_tick && phase == PH_BUF) begin
        if (left == CNT_W'(1)) begin
          pa_en <= 1'b1;
          left  <= pa_ticks(pa_hold);
          phase <= PH_PA;
        end else begin
          left <= left - CNT_W'(1);
        end
      end else if (us_tick && phase == PH_PA) begin
        if (left == CNT_W'(1)) begin
          shr   <= 1'b1;
          phase <= PH_AIR;
        end else begin
          left <= left - CNT_W'(1);
        end
      end
    end
  end

  // R11
  pa_needs_buf_chk: assert property (@(posedge clk) disable iff (rst)
    pa_en |-> buf_en);
  // R7
  shr_single_chk: assert property (@(posedge clk) disable iff (rst)
    shr |=> !shr);
  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && !tx_busy) |=> (!buf_en && !pa_en));
  // R5
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && start_req) |=> buf_en);
  // R10
  restart_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && tx_busy && start_req) |=> (buf_en && $stable(pa_hold)));
endmodule

// File: rtl/rf_fe_seq.sv
module rf_fe_seq
  import rf_fe_pkg::*;
#(
  parameter int LT_STEP = 2,
  parameter logic [CODE_W-1:0] BUF_LT_RST = CODE_W'(3),
  parameter logic [CODE_W-1:0] PA_LT_RST  = CODE_W'(0)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_fe_en,
  input  logic [CODE_W-1:0] cfg_buf_lt,
  input  logic [CODE_W-1:0] cfg_pa_lt,
  input  logic              tx_busy,
  input  logic              start_req,
  input  logic              us_tick,
  output logic              fe_tx_pin,
  output logic              fe_rx_pin,
  output logic              pa_buf_en,
  output logic              pa_en,
  output logic              shr_start
);
  fe_cfg_t wr_word;
  fe_cfg_t cfg_q;

  assign wr_word = '{fe_en: cfg_fe_en, buf_lt: cfg_buf_lt, pa_lt: cfg_pa_lt};

  rf_fe_cfg #(
    .BUF_LT_RST(BUF_LT_RST),
    .PA_LT_RST (PA_LT_RST)
  ) u_cfg (
    .clk  (clk),
    .rst  (rst),
    .we   (cfg_we),
    .wdata(wr_word),
    .cfg  (cfg_q)
  );

  rf_fe_pins u_pins (
    .clk    (clk),
    .rst    (rst),
    .fe_en  (cfg_q.fe_en),
    .tx_busy(tx_busy),
    .tx_pin (fe_tx_pin),
    .rx_pin (fe_rx_pin)
  );

  rf_fe_lead_seq #(
    .LT_STEP(LT_STEP)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .buf_lt   (cfg_q.buf_lt),
    .pa_lt    (cfg_q.pa_lt),
    .tx_busy  (tx_busy),
    .start_req(start_req),
    .us_tick  (us_tick),
    .buf_en   (pa_buf_en),
    .pa_en    (pa_en),
    .shr      (shr_start)
  );
endmodule

// File: tb/rf_fe_seq_test.sv
`timescale 1ns/1ps
module rf_fe_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic cfg_fe_en = 1'b0;
  logic [1:0] cfg_buf_lt = 2'd0;
  logic [1:0] cfg_pa_lt = 2'd0;
  logic tx_busy = 1'b0;
  logic start_req = 1'b0;
  logic us_tick = 1'b0;
  logic fe_tx_pin, fe_rx_pin, pa_buf_en, pa_en, shr_start;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rf_fe_seq uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_fe_en(cfg_fe_en),
    .cfg_buf_lt(cfg_buf_lt), .cfg_pa_lt(cfg_pa_lt), .tx_busy(tx_busy),
    .start_req(start_req), .us_tick(us_tick), .fe_tx_pin(fe_tx_pin),
    .fe_rx_pin(fe_rx_pin), .pa_buf_en(pa_buf_en), .pa_en(pa_en),
    .shr_start(shr_start)
  );

  // microsecond tick: one cycle in five
  int div = 0;
  always @(negedge clk) begin
    div = (div == 4) ? 0 : div + 1;
    us_tick <= (div == 4);
  end

  // behavioural reference
  bit m_en; int m_bl, m_pl;
  bit e_tx, e_rx, e_buf, e_pa, e_shr;
  string pin_tag = "R2";
  int m_phase, m_left, m_lat_pa;
  // port measurements
  int meas_buf, meas_pa;
  bit seen_shr;

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_bl = 3; m_pl = 0;
      e_tx = 0; e_rx = 0; e_buf = 0; e_pa = 0; e_shr = 0;
      m_phase = 0; m_left = 0; m_lat_pa = 0;
    end else begin
      if (start_req && !pa_buf_en) begin
        meas_buf = 0; meas_pa = 0; seen_shr = 0;
      end
      if (pa_buf_en && !pa_en && us_tick) meas_buf++;
      if (pa_en && !seen_shr && us_tick) meas_pa++;
      if (shr_start) seen_shr = 1;

      pin_tag = !m_en ? "R2" : (tx_busy ? "R3" : "R4");
      e_tx = m_en && tx_busy;
      e_rx = m_en && !tx_busy;
      e_shr = 0;
      if (m_phase == 0) begin
        if (start_req) begin
          e_buf = 1; m_lat_pa = m_pl;
          if (m_bl == 0) begin e_pa = 1; m_phase = 2; m_left = 2 * (m_pl + 1); end
          else begin m_phase = 1; m_left = 2 * m_bl; end
        end
      end else if (!tx_busy) begin
        e_buf = 0; e_pa = 0; m_phase = 0;
      end else if (us_tick && m_phase == 1) begin
        m_left--;
        if (m_left == 0) begin e_pa = 1; m_phase = 2; m_left = 2 * (m_lat_pa + 1); end
      end else if (us_tick && m_phase == 2) begin
        m_left--;
        if (m_left == 0) begin e_shr = 1; m_phase = 3; end
      end
      if (cfg_we) begin m_en = cfg_fe_en; m_bl = cfg_buf_lt; m_pl = cfg_pa_lt; end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(fe_tx_pin == e_tx, {pin_tag, " tx pin"}, fe_tx_pin, e_tx);
      check(fe_rx_pin == e_rx, {pin_tag, " rx pin"}, fe_rx_pin, e_rx);
      check(pa_buf_en == e_buf, "R5 buffer enable", pa_buf_en, e_buf);
      check(pa_en == e_pa, "R6 PA enable", pa_en, e_pa);
      check(shr_start == e_shr, "R7 header strobe", shr_start, e_shr);
      check(!(pa_en && !pa_buf_en), "R11 ordering", pa_en, 0);
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_cfg(input bit en, input int bl, input int pl);
    @(negedge clk);
    cfg_we = 1; cfg_fe_en = en; cfg_buf_lt = 2'(bl); cfg_pa_lt = 2'(pl);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic launch();
    @(negedge clk);
    tx_busy = 1; start_req = 1;
    @(negedge clk);
    start_req = 0;
  endtask

  task automatic wait_shr();
    for (int i = 0; i < 400 && !seen_shr; i++) @(negedge clk);
  endtask

  task automatic finish_frame();
    cycles(3);
    tx_busy = 0;
    cycles(2);
    check(!pa_buf_en && !pa_en, "R8 enables off after busy ends", pa_buf_en + pa_en, 0);
    cycles(2);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    cycles(3);
    rst = 0;
    @(negedge clk);
    // R1 reset state at the ports
    check({fe_tx_pin, fe_rx_pin, pa_buf_en, pa_en, shr_start} == 5'b0,
          "R1 outputs after reset", {fe_tx_pin, fe_rx_pin, pa_buf_en, pa_en, shr_start}, 0);
    // R2 control off, busy toggling
    tx_busy = 1; cycles(3); tx_busy = 0; cycles(3);

    // R1 default leads: buffer 6, PA 2
    launch(); wait_shr();
    check(meas_buf == 6, "R1 default buffer lead", meas_buf, 6);
    check(meas_pa == 2, "R1 default PA lead", meas_pa, 2);
    finish_frame();

    // R3 R4 pins with control on; R6 zero buffer lead; R7 longest PA lead
    write_cfg(1, 0, 3);
    tx_busy = 1; cycles(2); tx_busy = 0; cycles(2);
    launch(); wait_shr();
    check(meas_buf == 0, "R6 zero buffer lead", meas_buf, 0);
    check(meas_pa == 8, "R7 PA lead code 3", meas_pa, 8);
    finish_frame();

    // R9 write during a frame applies to the next frame only
    launch();
    write_cfg(1, 2, 1);
    wait_shr();
    check(meas_buf == 0, "R9 old buffer code kept", meas_buf, 0);
    check(meas_pa == 8, "R9 old PA code kept", meas_pa, 8);
    finish_frame();
    launch(); wait_shr();
    check(meas_buf == 4, "R9 new buffer code", meas_buf, 4);
    check(meas_pa == 4, "R9 new PA code", meas_pa, 4);
    finish_frame();

    // R10 second start during a frame is ignored
    launch();
    cycles(7);
    start_req = 1; @(negedge clk); start_req = 0;
    wait_shr();
    check(meas_buf == 4, "R10 buffer lead unchanged", meas_buf, 4);
    check(meas_pa == 4, "R10 PA lead unchanged", meas_pa, 4);
    finish_frame();

    // R8 busy drops during the buffer window
    write_cfg(0, 3, 2);
    launch();
    cycles(2);
    tx_busy = 0;
    cycles(2);
    check(!pa_buf_en && !pa_en, "R8 abort in buffer window", pa_buf_en + pa_en, 0);
    cycles(4);
    // R8 busy drops during the PA window
    write_cfg(1, 1, 3);
    launch();
    cycles(20);
    check(pa_en == 1, "R6 PA on before abort", pa_en, 1);
    tx_busy = 0;
    cycles(2);
    check(!pa_buf_en && !pa_en, "R8 abort in PA window", pa_buf_en + pa_en, 0);
    cycles(5);
    report();
  end
endmodule